// File: doc/BRIEF.md
# Floating-Point Status Flag Unit

This block keeps the 32-bit status word of a single-precision floating-point unit. Each completed arithmetic, compare or convert operation reports five exception indications plus two denormal indications. The block turns these into per-operation cause bits, sticky flag bits, a summary bit and a one-cycle exception request. It also takes masked software writes and drives the 2-bit rounding-mode selection to the datapath.

Flags are set only for exceptions whose enable is clear. When an exception is enabled, it is reported through the request instead. A denormal operand or result raises an unimplemented-processing cause. That cause cannot be masked, and it is suppressed only while denormal-flush mode is on.

The status word is laid out as follows:

| Bits | Field | Contents |
|------|-------|----------|
| 1:0 | rounding mode | 0 = nearest even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity |
| 2 | flush | denormal-flush mode |
| 8:3 | cause | one bit per indication, plus bit 8 for unimplemented processing |
| 13:9 | enable | one bit per exception |
| 18:14 | flag | one sticky bit per exception |
| 30:19 | reserved | always read 0 |
| 31 | summary | set when any flag bit is set |

Within the cause, enable and flag fields, the exceptions use the same order as indication bits 0 to 4: invalid, overflow, divide-by-zero, underflow, inexact.

Top module: `fpsr_unit`

## Requirements
- R1: After reset, `status_o` is 0, `rnd_mode_o` is 0 (round to nearest even) and `exc_req_o` is 0.
- R2: On `op_valid_i`, the cause bits from the previous operation are cleared. Each asserted `exc_i` bit k then sets cause bit 3+k (k = 0 invalid, 1 overflow, 2 divide-by-zero, 3 underflow, 4 inexact).
- R3: On an operation, flag bit 14+k is set when `exc_i[k]` is 1 and enable bit 9+k is 0. Flag bits are never cleared by an operation.
- R4: On an operation, cause bit 8 (unimplemented processing) is set when `denorm_in_i` or `denorm_out_i` is 1 and flush bit 2 is 0. While flush is 1, cause bit 8 stays 0.
- R5: Summary bit 31 equals the OR of flag bits 18:14 after every update.
- R6: During an operation cycle, `exc_req_o` is 1 exactly when the new cause bits 7:3 AND the enable bits 13:9 are non-zero, or when new cause bit 8 is set. `exc_vec_o` always reads 21.
- R7: `rnd_mode_o` equals status bits 1:0.
- R8: On `sw_we_i`, bits 18:0 take the written value and bits 30:19 read 0. Written bit 31 is ignored, and bit 31 is recomputed from the written flags.
- R9: When `sw_we_i` and `op_valid_i` are both 1, the write takes effect, the operation is dropped and `exc_req_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation result is reported this cycle |
| exc_i | input | 5 | Exception indications: invalid, overflow, divide-by-zero, underflow, inexact |
| denorm_in_i | input | 1 | Denormal operand seen |
| denorm_out_i | input | 1 | Denormal result produced |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 32 | Software write data |
| status_o | output | 32 | Status word |
| rnd_mode_o | output | 2 | Rounding mode to the datapath |
| exc_req_o | output | 1 | Exception request pulse |
| exc_vec_o | output | 8 | Exception vector index |

## Verification
The hardest case to reach from the ports is an operation that meets an arbitrary mix of preset sticky flags, enables and flush mode. That mix is what shows flag stickiness, enable masking and the unmaskable denormal cause working together. Before every operation, the bench writes a chosen status word through the software port. It then sweeps all enable patterns, all indication patterns, every denormal combination and both flush settings. The write value also carries set reserved bits and a set bit 31, so the masking of those bits is tested on every step.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int NUM_EXC    = 5;
  localparam int NUM_CAUSE  = NUM_EXC + 1;
  localparam int WORD_W     = 32;
  localparam int RND_W      = 2;
  localparam int FLAG_TOP   = RND_W + 1 + NUM_CAUSE + 2 * NUM_EXC - 1;
  localparam int RSVD_W     = WORD_W - 2 - FLAG_TOP;
  localparam int VEC_W      = 8;
  localparam logic [VEC_W-1:0] FP_EXC_VEC = 8'd21;

  typedef enum logic [RND_W-1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_TO_ZERO   = 2'd1,
    RND_TO_POS    = 2'd2,
    RND_TO_NEG    = 2'd3
  } rnd_mode_e;

  typedef struct packed {
    logic                 sum;
    logic [RSVD_W-1:0]    rsvd;
    logic [NUM_EXC-1:0]   flag;
    logic [NUM_EXC-1:0]   en;
    logic [NUM_CAUSE-1:0] cause;
    logic                 flush;
    rnd_mode_e            rnd;
  } fpsr_t;
endpackage

// File: rtl/fpsr_cause_gen.sv
module fpsr_cause_gen
  import fpsr_pkg::*;
(
  input  logic [NUM_EXC-1:0]   exc_i,
  input  logic                 denorm_in_i,
  input  logic                 denorm_out_i,
  input  logic                 flush_i,
  output logic [NUM_CAUSE-1:0] cause_o
);
  // top cause bit is the unmaskable unimplemented-processing cause
  assign cause_o = {(denorm_in_i | denorm_out_i) & ~flush_i, exc_i};
endmodule

// File: rtl/fpsr_trap_eval.sv
module fpsr_trap_eval
  import fpsr_pkg::*;
(
  input  logic [NUM_CAUSE-1:0] cause_i,
  input  logic [NUM_EXC-1:0]   en_i,
  output logic                 trap_o
);
  logic [NUM_CAUSE-1:0] en_full;
  logic [NUM_CAUSE-1:0] hit;

  assign en_full = {1'b1, en_i};

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_hit
    assign hit[g] = cause_i[g] & en_full[g];
  end

  assign trap_o = |hit;
endmodule

// File: rtl/fpsr_write_merge.sv
module fpsr_write_merge
  import fpsr_pkg::*;
(
  input  logic [WORD_W-1:0] wdata_i,
  output fpsr_t             word_o
);
  fpsr_t raw;

  assign raw = fpsr_t'(wdata_i);

  always_comb begin
    word_o      = raw;
    word_o.rsvd = '0;
    word_o.sum  = |raw.flag;
  end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  input  logic [4:0]          exc_i,
  input  logic                denorm_in_i,
  input  logic                denorm_out_i,
  input  logic                sw_we_i,
  input  logic [31:0]         sw_wdata_i,
  output logic [31:0]         status_o,
  output logic [1:0]          rnd_mode_o,
  output logic                exc_req_o,
  output logic [7:0]          exc_vec_o
);
  fpsr_t                q, d, wr_word;
  logic [NUM_CAUSE-1:0] cause_new;
  logic                 trap;
  logic                 op_take;

  fpsr_cause_gen i_cause (
    .exc_i       (exc_i),
    .denorm_in_i (denorm_in_i),
    .denorm_out_i(denorm_out_i),
    .flush_i     (q.flush),
    .cause_o     (cause_new)
  );

  fpsr_trap_eval i_trap (
    .cause_i(cause_new),
    .en_i   (q.en),
    .trap_o (trap)
  );

  fpsr_write_merge i_wr (
    .wdata_i(sw_wdata_i),
    .word_o (wr_word)
  );

  assign op_take = op_valid_i & ~sw_we_i;

  always_comb begin
    d = q;
    if (sw_we_i) begin
      d = wr_word;
    end else if (op_valid_i) begin
      d.cause = cause_new;
      d.flag  = q.flag | (cause_new[NUM_EXC-1:0] & ~q.en);
      d.sum   = |d.flag;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign status_o   = q;
  assign rnd_mode_o = q.rnd;
  assign exc_req_o  = op_take & trap;
  assign exc_vec_o  = FP_EXC_VEC;

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_take |=> ((q.flag & $past(q.flag)) == $past(q.flag))); // R3
  AST_NO_FLAG_WHEN_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_take |=> ((q.flag & ~$past(q.flag) & $past(q.en)) == '0)); // R3
  AST_FLUSH_BLOCKS_UNIMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_take && q.flush) |=> !q.cause[NUM_CAUSE-1]); // R4
  AST_SUMMARY_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q.sum == (|q.flag)); // R5
  AST_REQ_LEAVES_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |=> (|q.cause)); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q.rsvd == '0); // R8
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && op_valid_i) |-> !exc_req_o); // R9
endmodule

// File: tb/test_fpsr_unit.sv
`timescale 1ns/1ps
module test_fpsr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [4:0]  exc_i = '0;
  logic        denorm_in_i = 1'b0;
  logic        denorm_out_i = 1'b0;
  logic        sw_we_i = 1'b0;
  logic [31:0] sw_wdata_i = '0;
  logic [31:0] status_o;
  logic [1:0]  rnd_mode_o;
  logic        exc_req_o;
  logic [7:0]  exc_vec_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fpsr_unit i_fpsr_unit (
    .clk_i, .rst_ni, .op_valid_i, .exc_i, .denorm_in_i, .denorm_out_i,
    .sw_we_i, .sw_wdata_i, .status_o, .rnd_mode_o, .exc_req_o, .exc_vec_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [4:0] fl, logic [4:0] en, logic [5:0] ca,
                                     logic fz, logic [1:0] rm);
    return {|fl, 12'b0, fl, en, ca, fz, rm};
  endfunction

  task automatic sw_write(logic [31:0] w);
    @(negedge clk_i);
    sw_we_i = 1'b1; sw_wdata_i = w;
    @(posedge clk_i); #1;
    sw_we_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, exp_w;
    logic [5:0]  ca;
    logic [4:0]  pf, fl;
    logic        er;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 status", status_o, 32'h0);
    chk("R1 rnd", {30'b0, rnd_mode_o}, 32'h0);
    chk("R1 req", {31'b0, exc_req_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int rm = 0; rm < 4; rm++) begin
      sw_write(32'(rm));
      chk("R7 rnd", {30'b0, rnd_mode_o}, 32'(rm));
    end

    for (int en = 0; en < 32; en++)
      for (int ex = 0; ex < 32; ex++)
        for (int dn = 0; dn < 4; dn++)
          for (int fz = 0; fz < 2; fz++) begin
            pf = 5'((en * 3 + ex + dn) & 31);
            // bit 31 and reserved bits set: must be dropped
            w = {1'b1, 12'hfff, pf, 5'(en), 6'h3f, 1'(fz), 2'(ex)};
            sw_write(w);
            if (ex[2:0] == 0)
              chk("R8 write", status_o, mk(pf, 5'(en), 6'h3f, 1'(fz), 2'(ex)));
            ca = {(dn != 0) && (fz == 0), 5'(ex)};
            er = |(ca & {1'b1, 5'(en)});
            fl = pf | (5'(ex) & ~5'(en));
            exp_w = mk(fl, 5'(en), ca, 1'(fz), 2'(ex));
            @(negedge clk_i);
            op_valid_i = 1'b1; exc_i = 5'(ex);
            denorm_in_i = dn[0]; denorm_out_i = dn[1];
            #1;
            chk("R6 req", {31'b0, exc_req_o}, {31'b0, er});
            @(posedge clk_i); #1;
            op_valid_i = 1'b0; exc_i = '0; denorm_in_i = 0; denorm_out_i = 0;
            chk("R2 R3 R4 R5 status", status_o, exp_w);
          end

    chk("R6 vector", {24'b0, exc_vec_o}, 32'd21);

    // R9: collision
    sw_write(32'h0);
    @(negedge clk_i);
    op_valid_i = 1'b1; exc_i = 5'h1f; denorm_in_i = 1'b1;
    sw_we_i = 1'b1; sw_wdata_i = {1'b1, 12'h0, 5'h00, 5'h1f, 6'h00, 1'b1, 2'd3};
    #1;
    chk("R9 req", {31'b0, exc_req_o}, 32'h0);
    @(posedge clk_i); #1;
    op_valid_i = 1'b0; sw_we_i = 1'b0; exc_i = '0; denorm_in_i = 1'b0;
    chk("R9 status", status_o, mk(5'h00, 5'h1f, 6'h00, 1'b1, 2'd3));
    chk("R7 after write", {30'b0, rnd_mode_o}, 32'd3);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule